// File: doc/BRIEF.md
# Row Spare Matcher with Remappable Fuse-Sets

This block decides, for every row access into a sixteen-bank memory mat, whether the addressed row is served by its normal wordline or by a spare row. Each bank carries four spare rows, which gives sixty-four spares. Only twenty-seven fuse-sets hold the addresses of defective rows, so the fuse-sets are fewer than the spares. No fuse-set is wired to a fixed spare. Each fuse-set stores a 12-bit defective row address. The upper four bits of that address name the bank. The fuse-set also stores a 2-bit slot code that picks one of the four spares inside that bank.

The fuse contents arrive from holding registers. An init strobe captures them once. During that capture, each slot code is expanded into one-hot spare-select lines, so the remapping adds no decoding to the access path. After that, every valid row address is compared against all enabled fuse-sets in parallel. On a match, the normal wordline is suppressed and a 6-bit spare index is reported. The index has the form bank*4 + slot.

Top module: `row_repair_matcher`

## Requirements
- R1: While reset is held, and immediately after it is released, normal_wl_en, spare_hit, multi_hit and spare_idx are all 0.
- R2: Until the first init strobe has been taken, every valid access produces normal_wl_en=1 and spare_hit=0, whatever the fuse inputs hold.
- R3: An init strobe captures the fuse enable, address and slot inputs. Changes to those inputs afterwards have no effect on matching until the next init strobe, which captures the new values.
- R4: A valid access whose address equals the captured address of an enabled fuse-set produces spare_hit=1 and normal_wl_en=0.
- R5: On a hit, spare_idx equals {row_addr[11:8], slot}. The slot is the 2-bit code captured for the winning fuse-set, so spare_idx = bank*4 + slot, in the range 0 to 63.
- R6: A fuse-set whose enable bit was 0 at capture never matches, even when its captured address equals the access address.
- R7: A valid access that matches no enabled fuse-set produces normal_wl_en=1, spare_hit=0, multi_hit=0 and spare_idx=0.
- R8: When two or more enabled fuse-sets match, multi_hit=1 and the lowest-numbered matching fuse-set supplies the slot. When a single fuse-set matches, multi_hit=0.
- R9: A cycle with row_valid=0 produces all outputs 0 in the following cycle.
- R10: Every result appears exactly one clock after its access, and accesses may be issued on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fuse_en | input | 27 | Per-fuse-set enable, bit s for fuse-set s |
| fuse_addr | input | 324 | Defective row addresses, fuse-set s at bits [12s+11:12s] |
| fuse_map | input | 54 | Spare slot codes, fuse-set s at bits [2s+1:2s] |
| init_strobe | input | 1 | Captures the fuse inputs and arms matching |
| row_valid | input | 1 | Row access present this cycle |
| row_addr | input | 12 | Row address, bits [11:8] are the bank |
| normal_wl_en | output | 1 | Normal wordline enabled for the previous access |
| spare_hit | output | 1 | Previous access is redirected to a spare |
| spare_idx | output | 6 | Spare row number, bank*4 + slot |
| multi_hit | output | 1 | More than one fuse-set matched the previous access |

## Verification
Each result is due one clock after its access. The init strobe takes effect on the access in the cycle after the strobe. The bench drives each access on a falling edge and pushes the predicted result into a queue. A monitor pops that entry shortly after the next rising edge, so each comparison falls in exactly the cycle the result is registered. Idle cycles push an all-zero prediction. Back-to-back accesses push one entry per cycle, so any extra or missing cycle of latency shows up as a mismatch against a neighbouring access.

// File: rtl/rr_pkg.sv
package rr_pkg;
    localparam int RR_BANKS     = 16;
    localparam int RR_SLOTS     = 4;
    localparam int RR_SETS      = 27;
    localparam int RR_ADDR_W    = 12;
    localparam int RR_BANK_W    = $clog2(RR_BANKS);
    localparam int RR_MAP_W     = $clog2(RR_SLOTS);

    typedef enum logic {
        RR_COLD  = 1'b0,
        RR_ARMED = 1'b1
    } rr_phase_e;
endpackage

// File: rtl/rr_fuse_store.sv
module rr_fuse_store #(
    parameter int NUM_SETS = 27,
    parameter int ADDR_W   = 12,
    parameter int MAP_W    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [NUM_SETS-1:0]         fuse_en_i,
    input  logic [NUM_SETS*ADDR_W-1:0]  fuse_addr_i,
    input  logic [NUM_SETS*MAP_W-1:0]   fuse_map_i,
    input  logic [ADDR_W-1:0]           row_addr_i,
    output logic [NUM_SETS-1:0]         match_o,
    output logic [NUM_SETS*(1<<MAP_W)-1:0] sel_o
);
    localparam int NSP = 1 << MAP_W;

    typedef struct packed {
        logic [NUM_SETS-1:0]             en;
        logic [NUM_SETS-1:0][ADDR_W-1:0] addr;
        logic [NUM_SETS-1:0][NSP-1:0]    sel;
    } store_t;

    store_t st_d, st_q;

    // Capture and one-hot expansion of slot codes happen only on load.
    always_comb begin
        st_d = st_q;
        if (load) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                st_d.en[s]   = fuse_en_i[s];
                st_d.addr[s] = fuse_addr_i[s*ADDR_W +: ADDR_W];
                st_d.sel[s]  = '0;
                st_d.sel[s][fuse_map_i[s*MAP_W +: MAP_W]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar g = 0; g < NUM_SETS; g++) begin : g_cmp
            assign match_o[g]           = st_q.en[g] && (st_q.addr[g] == row_addr_i);
            assign sel_o[g*NSP +: NSP]  = st_q.sel[g];
        end
    endgenerate
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int NUM_SETS = 27,
    parameter int MAP_W    = 2
) (
    input  logic [NUM_SETS-1:0]            match_i,
    input  logic [NUM_SETS*(1<<MAP_W)-1:0] sel_i,
    output logic                           any_o,
    output logic                           multi_o,
    output logic [MAP_W-1:0]               slot_o
);
    localparam int NSP = 1 << MAP_W;

    logic [NSP-1:0] win_sel;

    // Scan from the top down so the lowest matching index is written last.
    always_comb begin
        win_sel = '0;
        for (int s = NUM_SETS - 1; s >= 0; s--) begin
            if (match_i[s]) win_sel = sel_i[s*NSP +: NSP];
        end
        slot_o = '0;
        for (int k = 0; k < NSP; k++) begin
            if (win_sel[k]) slot_o = MAP_W'(k);
        end
        any_o   = |match_i;
        multi_o = (match_i & (match_i - NUM_SETS'(1))) != '0;
    end
endmodule

// File: rtl/row_repair_matcher.sv
module row_repair_matcher
    import rr_pkg::*;
#(
    parameter int NUM_SETS = RR_SETS,
    parameter int ADDR_W   = RR_ADDR_W,
    parameter int BANK_W   = RR_BANK_W,
    parameter int MAP_W    = RR_MAP_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SETS-1:0]         fuse_en,
    input  logic [NUM_SETS*ADDR_W-1:0]  fuse_addr,
    input  logic [NUM_SETS*MAP_W-1:0]   fuse_map,
    input  logic                        init_strobe,
    input  logic                        row_valid,
    input  logic [ADDR_W-1:0]           row_addr,
    output logic                        normal_wl_en,
    output logic                        spare_hit,
    output logic [BANK_W+MAP_W-1:0]     spare_idx,
    output logic                        multi_hit
);
    localparam int IDX_W = BANK_W + MAP_W;
    localparam int NSP   = 1 << MAP_W;

    typedef struct packed {
        rr_phase_e        phase;
        logic             nwl;
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic             multi;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_SETS-1:0]     match_w;
    logic [NUM_SETS*NSP-1:0] sel_w;
    logic                    any_w;
    logic                    multi_w;
    logic [MAP_W-1:0]        slot_w;
    logic                    armed_w;

    rr_fuse_store #(
        .NUM_SETS (NUM_SETS),
        .ADDR_W   (ADDR_W),
        .MAP_W    (MAP_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (init_strobe),
        .fuse_en_i   (fuse_en),
        .fuse_addr_i (fuse_addr),
        .fuse_map_i  (fuse_map),
        .row_addr_i  (row_addr),
        .match_o     (match_w),
        .sel_o       (sel_w)
    );

    rr_pick #(
        .NUM_SETS (NUM_SETS),
        .MAP_W    (MAP_W)
    ) u_pick (
        .match_i (match_w),
        .sel_i   (sel_w),
        .any_o   (any_w),
        .multi_o (multi_w),
        .slot_o  (slot_w)
    );

    assign armed_w = (s_q.phase == RR_ARMED);

    always_comb begin
        s_d       = s_q;
        s_d.nwl   = 1'b0;
        s_d.hit   = 1'b0;
        s_d.idx   = '0;
        s_d.multi = 1'b0;
        if (init_strobe) s_d.phase = RR_ARMED;
        if (row_valid) begin
            if (armed_w && any_w) begin
                s_d.hit   = 1'b1;
                s_d.idx   = {row_addr[ADDR_W-1 -: BANK_W], slot_w};
                s_d.multi = multi_w;
            end else begin
                s_d.nwl   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{phase: RR_COLD, nwl: 1'b0, hit: 1'b0, idx: '0, multi: 1'b0};
        else        s_q <= s_d;
    end

    assign normal_wl_en = s_q.nwl;
    assign spare_hit    = s_q.hit;
    assign spare_idx    = s_q.idx;
    assign multi_hit    = s_q.multi;
endmodule

// File: rtl/rr_checker.sv
module rr_checker #(
    parameter int ADDR_W = 12,
    parameter int BANK_W = 4,
    parameter int MAP_W  = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    row_valid,
    input logic [ADDR_W-1:0]       row_addr,
    input logic                    armed,
    input logic                    normal_wl_en,
    input logic                    spare_hit,
    input logic [BANK_W+MAP_W-1:0] spare_idx,
    input logic                    multi_hit
);
    p_hit_kills_normal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spare_hit |-> !normal_wl_en);

    p_cold_no_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !spare_hit);

    p_bank_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid |=> (!spare_hit || spare_idx[BANK_W+MAP_W-1 -: BANK_W] == $past(row_addr[ADDR_W-1 -: BANK_W])));

    p_multi_needs_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> spare_hit);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !row_valid |=> (!normal_wl_en && !spare_hit && !multi_hit));

    p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid |=> (normal_wl_en != spare_hit));
endmodule

bind row_repair_matcher rr_checker #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .MAP_W  (MAP_W)
) u_rr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .row_valid    (row_valid),
    .row_addr     (row_addr),
    .armed        (armed_w),
    .normal_wl_en (normal_wl_en),
    .spare_hit    (spare_hit),
    .spare_idx    (spare_idx),
    .multi_hit    (multi_hit)
);

// File: tb/row_repair_matcher_bench.sv
`timescale 1ns/1ps
module row_repair_matcher_bench;
    localparam int NS = 27;
    localparam int AW = 12;
    localparam int MW = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NS-1:0]    fuse_en = '0;
    logic [NS*AW-1:0] fuse_addr = '0;
    logic [NS*MW-1:0] fuse_map = '0;
    logic             init_strobe = 1'b0;
    logic             row_valid = 1'b0;
    logic [AW-1:0]    row_addr = '0;
    logic             normal_wl_en, spare_hit, multi_hit;
    logic [5:0]       spare_idx;

    always #5 clk = ~clk;

    row_repair_matcher u_row_repair_matcher (
        .clk(clk), .rst_n(rst_n), .fuse_en(fuse_en), .fuse_addr(fuse_addr),
        .fuse_map(fuse_map), .init_strobe(init_strobe), .row_valid(row_valid),
        .row_addr(row_addr), .normal_wl_en(normal_wl_en), .spare_hit(spare_hit),
        .spare_idx(spare_idx), .multi_hit(multi_hit)
    );

    typedef struct {
        logic       nwl;
        logic       hit;
        logic       multi;
        logic [5:0] idx;
        string      tag;
    } exp_t;

    exp_t      sb[$];
    int        checks = 0;
    int        errors = 0;
    logic      m_armed = 1'b0;
    logic      m_en   [NS];
    logic [11:0] m_addr [NS];
    logic [1:0]  m_map  [NS];

    task automatic set_fuse(int s, logic en, logic [11:0] a, logic [1:0] m);
        fuse_en[s]          = en;
        fuse_addr[s*AW +: AW] = a;
        fuse_map[s*MW +: MW]  = m;
    endtask

    task automatic do_init();
        @(negedge clk);
        init_strobe = 1'b1;
        row_valid   = 1'b0;
        for (int s = 0; s < NS; s++) begin
            m_en[s]   = fuse_en[s];
            m_addr[s] = fuse_addr[s*AW +: AW];
            m_map[s]  = fuse_map[s*MW +: MW];
        end
        m_armed = 1'b1;
        @(negedge clk);
        init_strobe = 1'b0;
    endtask

    task automatic access(logic [11:0] a, string tag);
        exp_t e;
        int   cnt;
        @(negedge clk);
        row_valid = 1'b1;
        row_addr  = a;
        e = '{nwl: 1'b1, hit: 1'b0, multi: 1'b0, idx: 6'd0, tag: tag};
        cnt = 0;
        if (m_armed) begin
            for (int s = NS - 1; s >= 0; s--) begin
                if (m_en[s] && m_addr[s] == a) begin
                    cnt++;
                    e.idx = {a[11:8], m_map[s]};
                end
            end
            if (cnt > 0) begin
                e.nwl   = 1'b0;
                e.hit   = 1'b1;
                e.multi = (cnt > 1);
            end else begin
                e.idx = 6'd0;
            end
        end
        sb.push_back(e);
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        row_valid = 1'b0;
        sb.push_back('{nwl: 1'b0, hit: 1'b0, multi: 1'b0, idx: 6'd0, tag: tag});
    endtask

    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (normal_wl_en !== e.nwl || spare_hit !== e.hit ||
                multi_hit !== e.multi || spare_idx !== e.idx) begin
                errors++;
                $display("FAIL %s: got nwl=%0b hit=%0b multi=%0b idx=%0d, expected nwl=%0b hit=%0b multi=%0b idx=%0d",
                         e.tag, normal_wl_en, spare_hit, multi_hit, spare_idx,
                         e.nwl, e.hit, e.multi, e.idx);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++) set_fuse(s, 1'b0, 12'(s * 37 + 1), 2'(s));
        set_fuse(0,  1'b1, 12'h123, 2'd2);
        set_fuse(5,  1'b1, 12'hF00, 2'd3);
        set_fuse(7,  1'b0, 12'h456, 2'd0);
        set_fuse(10, 1'b1, 12'h789, 2'd1);
        set_fuse(12, 1'b1, 12'h789, 2'd3);
        set_fuse(26, 1'b1, 12'h000, 2'd0);

        repeat (3) @(negedge clk);
        checks++;
        if (normal_wl_en !== 1'b0 || spare_hit !== 1'b0 || multi_hit !== 1'b0 || spare_idx !== 6'd0) begin
            errors++;
            $display("FAIL R1: got nwl=%0b hit=%0b multi=%0b idx=%0d, expected all 0",
                     normal_wl_en, spare_hit, multi_hit, spare_idx);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (normal_wl_en !== 1'b0 || spare_hit !== 1'b0 || multi_hit !== 1'b0 || spare_idx !== 6'd0) begin
            errors++;
            $display("FAIL R1: got nwl=%0b hit=%0b multi=%0b idx=%0d after release, expected all 0",
                     normal_wl_en, spare_hit, multi_hit, spare_idx);
        end

        access(12'h123, "R2 cold access to fused address");
        access(12'h789, "R2 cold access to doubly fused address");
        idle("R9 idle before init");

        do_init();
        access(12'h123, "R4 R5 hit set0 slot2 bank1");
        access(12'hF00, "R5 top bank top slot");
        access(12'h000, "R5 bank0 slot0");
        access(12'h456, "R6 disabled set");
        access(12'h124, "R7 miss");
        access(12'h789, "R8 multi hit lowest set wins");
        idle("R9 idle after access");
        access(12'h123, "R10 back-to-back 1");
        access(12'h124, "R10 back-to-back 2");
        access(12'hF00, "R10 back-to-back 3");
        idle("R9 idle");

        set_fuse(0, 1'b1, 12'h555, 2'd1);
        set_fuse(7, 1'b1, 12'h456, 2'd0);
        access(12'h123, "R3 stale capture still hits");
        access(12'h555, "R3 new address ignored before strobe");
        access(12'h456, "R3 new enable ignored before strobe");
        idle("R9 idle");

        do_init();
        access(12'h555, "R3 recaptured address hits");
        access(12'h123, "R3 old address now misses");
        access(12'h456, "R3 recaptured enable hits");
        access(12'h789, "R8 multi hit after recapture");
        idle("R9 final idle");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R10: got %0d unconsumed results, expected 0", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule